// File: doc/BRIEF.md
# Half-Bridge Output Fault Supervisor

This block guards the twelve power switches of six half-bridges, one high-side and one low-side switch per bridge. It watches a per-switch overcurrent flag, a supply undervoltage flag, a temperature prewarning flag and an overtemperature flag. It runs the qualification timers on a slow time-base tick, keeps the fault flags in latches and drives a per-switch force-off mask that the output stage ANDs with its own commanded state.

An overcurrent that persists for a selectable delay turns its own switch off and sets the short flag. While the prewarning is active the delay is skipped. A qualified undervoltage turns every switch off for as long as it lasts and leaves a sticky supply-fail flag behind. Overtemperature turns every switch off until the die has cooled and the control interface has issued a status reset. The same status-reset strobe clears the short and supply-fail flags.

Mask bit order: bit 2k is the low-side switch of bridge k and bit 2k+1 is its high-side switch. Every mask bit is handled the same way.

Top module: `fault_supervisor`

## Requirements
- R1: When `oc_i[n]` stays high for N consecutive time-base ticks, `sw_off_o[n]` and `short_o` go high on the clock edge that counts the Nth tick. N is `SC_FAST_TICKS` when `slow_dly_i`=0 and `SC_SLOW_TICKS` when `slow_dly_i`=1.
- R2: A cycle with `oc_i[n]` low restarts that switch's timer from zero. Clock cycles without `tick_i` do not advance the timer.
- R3: When `oc_i[n]` and `prewarn_i` are both high, switch n is latched off on the next clock edge, without waiting for the delay.
- R4: Each switch has its own timer and latch. An overcurrent on one switch never sets the force-off bit of another.
- R5: A `status_rst_i` pulse clears every short latch and `short_o` on the next edge, which re-enables the shorted switches. This clear wins over a short trip in the same cycle.
- R6: When `uv_i` stays high for `UV_TICKS` ticks, `supply_fail_o` and all `sw_off_o` bits are set on the edge of the last tick. A gap in `uv_i` restarts the undervoltage timer.
- R7: When `uv_i` falls, the undervoltage part of the force-off mask is released in the same cycle, with no clock edge needed. `supply_fail_o` stays high until a `status_rst_i` pulse that arrives while `uv_i` is low.
- R8: When `overtemp_i` is high, `ot_shutdown_o` and all `sw_off_o` bits are high from the next edge on.
- R9: The thermal latch clears only on a `status_rst_i` pulse while `overtemp_i` is low. A status reset while `overtemp_i` is high is ignored, and cooling alone does not clear the latch.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse from the slow time base |
| oc_i | input | NUM_SW | Overcurrent flag for each switch |
| uv_i | input | 1 | Supply undervoltage flag |
| prewarn_i | input | 1 | Temperature prewarning flag |
| overtemp_i | input | 1 | Overtemperature flag |
| slow_dly_i | input | 1 | Selects the short-circuit delay: 0 short, 1 long |
| status_rst_i | input | 1 | Status-reset strobe from the control interface |
| short_o | output | 1 | At least one switch is latched off for a short |
| supply_fail_o | output | 1 | Sticky supply-fail flag |
| ot_shutdown_o | output | 1 | Thermal shutdown latch |
| sw_off_o | output | NUM_SW | Force-off mask, one bit per switch |

## Verification
The assertions check these rules on every cycle: a short latch may set only after its overcurrent flag was high, the prewarning bypass trips within one edge, a status reset always empties the short latches, and the supply-fail and thermal flags cannot fall without a status reset. Only the bench scenarios can show the exact trip cycle of each delay setting on each of the twelve switches. The same holds for the restart after a gap, the pause while no tick arrives, the release of the undervoltage mask with no clock edge, and the order in which cooling and reset must occur before the thermal latch lets go.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/fps_short_timer.sv
`timescale 1ns/1ps
module fps_short_timer #(
  parameter int FAST_TICKS = 48,
  parameter int SLOW_TICKS = 384,
  localparam int CW = fps_pkg::cnt_width(SLOW_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic oc_i,
  input  logic prewarn_i,
  input  logic slow_dly_i,
  input  logic clear_i,
  output logic latched_o
);
  localparam logic [CW-1:0] FastLim = CW'(FAST_TICKS - 1);
  localparam logic [CW-1:0] SlowLim = CW'(SLOW_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;
  logic [CW-1:0] lim;
  logic          trip;

  assign lim  = slow_dly_i ? SlowLim : FastLim;
  // >= covers a switch from the long to the short delay in mid-count
  assign trip = oc_i & ~lat_q & (prewarn_i | (tick_i & (cnt_q >= lim)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (lat_q || !oc_i) begin
      cnt_q <= '0;
    end else if (trip) begin
      cnt_q <= '0;
      lat_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/fps_uv_qual.sv
`timescale 1ns/1ps
module fps_uv_qual #(
  parameter int UV_TICKS = 448,
  localparam int CW = fps_pkg::cnt_width(UV_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic uv_i,
  input  logic clear_i,
  output logic uv_off_o,
  output logic fail_o
);
  localparam logic [CW-1:0] UvLim = CW'(UV_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          qual_q;
  logic          fail_q;
  logic          trip;

  assign trip = uv_i & ~qual_q & tick_i & (cnt_q >= UvLim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (!uv_i) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (trip) begin
      cnt_q  <= '0;
      qual_q <= 1'b1;
    end else if (tick_i && !qual_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the flag stays pinned while undervoltage persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= trip | (qual_q & uv_i) | (fail_q & ~clear_i);
  end

  // release needs no clock edge
  assign uv_off_o = qual_q & uv_i;
  assign fail_o   = fail_q;
endmodule

// File: rtl/fps_thermal_latch.sv
`timescale 1ns/1ps
module fps_thermal_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic overtemp_i,
  input  logic clear_i,
  output logic shutdown_o
);
  logic sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sd_q <= 1'b0;
    else if (overtemp_i)              sd_q <= 1'b1;
    else if (clear_i)                 sd_q <= 1'b0;
  end

  assign shutdown_o = sd_q;
endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor #(
  parameter int NUM_BRIDGES   = 6,
  parameter int SC_FAST_TICKS = 48,
  parameter int SC_SLOW_TICKS = 384,
  parameter int UV_TICKS      = 448,
  localparam int NUM_SW = 2 * NUM_BRIDGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_SW-1:0] oc_i,
  input  logic              uv_i,
  input  logic              prewarn_i,
  input  logic              overtemp_i,
  input  logic              slow_dly_i,
  input  logic              status_rst_i,
  output logic              short_o,
  output logic              supply_fail_o,
  output logic              ot_shutdown_o,
  output logic [NUM_SW-1:0] sw_off_o
);
  logic [NUM_SW-1:0] short_q;
  logic              uv_off;
  logic              ot_q;

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    fps_short_timer #(
      .FAST_TICKS(SC_FAST_TICKS),
      .SLOW_TICKS(SC_SLOW_TICKS)
    ) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .oc_i      (oc_i[g]),
      .prewarn_i (prewarn_i),
      .slow_dly_i(slow_dly_i),
      .clear_i   (status_rst_i),
      .latched_o (short_q[g])
    );
  end

  fps_uv_qual #(.UV_TICKS(UV_TICKS)) u_uv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .uv_i    (uv_i),
    .clear_i (status_rst_i),
    .uv_off_o(uv_off),
    .fail_o  (supply_fail_o)
  );

  fps_thermal_latch u_th (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .overtemp_i(overtemp_i),
    .clear_i   (status_rst_i),
    .shutdown_o(ot_q)
  );

  assign short_o       = |short_q;
  assign ot_shutdown_o = ot_q;
  assign sw_off_o      = short_q | {NUM_SW{uv_off | ot_q}};
endmodule

// File: rtl/fault_supervisor_chk.sv
`timescale 1ns/1ps
module fault_supervisor_chk #(
  parameter int NUM_SW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_SW-1:0] oc_i,
  input logic              prewarn_i,
  input logic              overtemp_i,
  input logic              status_rst_i,
  input logic [NUM_SW-1:0] short_q,
  input logic              supply_fail_o,
  input logic              ot_shutdown_o,
  input logic [NUM_SW-1:0] sw_off_o
);
  // R1
  short_needs_oc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((short_q & ~$past(short_q) & ~$past(oc_i)) == '0));

  // R3
  prewarn_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prewarn_i && !status_rst_i && (oc_i != '0)) |=> ((short_q & $past(oc_i)) == $past(oc_i)));

  // R5
  short_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rst_i |=> (short_q == '0));

  // R7
  supply_fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_fail_o && !status_rst_i) |=> supply_fail_o);

  // R8
  ot_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overtemp_i |=> (ot_shutdown_o && (&sw_off_o)));

  // R9
  ot_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_shutdown_o && (!status_rst_i || overtemp_i)) |=> ot_shutdown_o);
endmodule

bind fault_supervisor fault_supervisor_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .oc_i         (oc_i),
  .prewarn_i    (prewarn_i),
  .overtemp_i   (overtemp_i),
  .status_rst_i (status_rst_i),
  .short_q      (short_q),
  .supply_fail_o(supply_fail_o),
  .ot_shutdown_o(ot_shutdown_o),
  .sw_off_o     (sw_off_o)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
  localparam int NB   = 6;
  localparam int NSW  = 2 * NB;
  localparam int FAST = 3;
  localparam int SLOW = 6;
  localparam int UVT  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b1;
  logic [NSW-1:0] oc = '0;
  logic           uv = 1'b0, pw = 1'b0, ot = 1'b0, sel = 1'b0, srst = 1'b0;
  logic           short_o, sf_o, ots_o;
  logic [NSW-1:0] off_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(
    .NUM_BRIDGES(NB), .SC_FAST_TICKS(FAST), .SC_SLOW_TICKS(SLOW), .UV_TICKS(UVT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .oc_i(oc), .uv_i(uv),
    .prewarn_i(pw), .overtemp_i(ot), .slow_dly_i(sel), .status_rst_i(srst),
    .short_o(short_o), .supply_fail_o(sf_o), .ot_shutdown_o(ots_o), .sw_off_o(off_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NSW-1:0] act, input logic [NSW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse_rst_status();
    srst = 1'b1;
    step(1);
    srst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: act=running exp=done");
    finish_run();
  end

  initial begin
    step(2);
    // R10 reset state
    chk("R10 outputs", {off_o[NSW-1:3], short_o, sf_o, ots_o}, '0);
    chk("R10 mask", off_o, '0);
    rst_n = 1'b1;
    step(1);

    // R1 R4 R5 sweep: every switch, both delay settings
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < NSW; i++) begin
        int lim;
        lim = (s == 1) ? SLOW : FAST;
        sel = s[0];
        oc = NSW'(1) << i;
        step(lim - 1);
        chk("R1 before delay", off_o, '0);
        step(1);
        chk("R1 R4 trip mask", off_o, NSW'(1) << i);
        chk("R1 short flag", NSW'(short_o), NSW'(1));
        oc = '0;
        pulse_rst_status();
        chk("R5 cleared", {off_o[NSW-2:0], short_o}, '0);
      end
    end

    // R2 gap restarts the timer
    sel = 1'b0;
    oc = 12'h001;
    step(FAST - 1);
    oc = '0;
    step(1);
    oc = 12'h001;
    step(FAST - 1);
    chk("R2 gap restart", off_o, '0);
    step(1);
    chk("R2 trip after restart", off_o, 12'h001);
    oc = '0;
    pulse_rst_status();

    // R2 no tick, no progress
    oc = 12'h004;
    tick = 1'b0;
    step(3 * SLOW);
    chk("R2 no tick", off_o, '0);
    tick = 1'b1;
    step(FAST);
    chk("R2 tick resumes", off_o, 12'h004);
    oc = '0;
    pulse_rst_status();

    // R3 prewarning bypass on two switches at once
    sel = 1'b1;
    pw = 1'b1;
    oc = 12'h820;
    step(1);
    chk("R3 bypass", off_o, 12'h820);
    oc = '0;
    pw = 1'b0;
    pulse_rst_status();
    chk("R5 after bypass", off_o, '0);

    // R5 clear wins over a trip in the same cycle
    pw = 1'b1;
    oc = 12'h010;
    srst = 1'b1;
    step(1);
    srst = 1'b0;
    chk("R5 clear priority", off_o, '0);
    oc = '0;
    pw = 1'b0;
    step(1);

    // R6 undervoltage qualification with a gap
    uv = 1'b1;
    step(UVT - 1);
    uv = 1'b0;
    step(1);
    uv = 1'b1;
    step(UVT - 1);
    chk("R6 before delay", {off_o[NSW-2:0], sf_o}, '0);
    step(1);
    chk("R6 all off", off_o, '1);
    chk("R6 supply fail", NSW'(sf_o), NSW'(1));
    pulse_rst_status();
    chk("R7 reset ignored under uv", NSW'(sf_o), NSW'(1));

    // R7 immediate release, sticky flag
    uv = 1'b0;
    #1;
    chk("R7 immediate release", off_o, '0);
    step(2);
    chk("R7 flag sticky", NSW'(sf_o), NSW'(1));
    pulse_rst_status();
    chk("R7 flag cleared", NSW'(sf_o), '0);

    // R8 R9 thermal latch
    ot = 1'b1;
    step(1);
    chk("R8 all off", off_o, '1);
    chk("R8 flag", NSW'(ots_o), NSW'(1));
    pulse_rst_status();
    chk("R9 reset while hot", NSW'(ots_o), NSW'(1));
    ot = 1'b0;
    step(3);
    chk("R9 cooled, no reset", off_o, '1);
    pulse_rst_status();
    chk("R9 released", {off_o[NSW-2:0], ots_o}, '0);

    finish_run();
  end
endmodule